// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C style) that exposes a small bank of 8-bit configuration registers to a host. Both bus lines are brought into the local clock domain, then filtered so that short glitches are dropped. The block detects START, repeated START and STOP, and answers to a 7-bit address. The two lowest address bits come from pins, so up to four of these targets can share one bus. SDA is never driven high. The block only pulls it low through an output-enable.

In a write transaction, the first byte after the address loads a register pointer and every byte after that is stored at the pointer. A read transaction returns the byte at the pointer. The same pointer advances by one after every data byte, whether written or read, and it wraps from 0xFF to 0x00. So a host usually writes the pointer, issues a repeated START and reads a burst. Register 0x00 is a read-only identity byte. Bit 0 of register 0x0C is a command bit: its level is handed to a calibration controller, which clears it by pulsing a completion input. All register contents appear on a flat output bus that drives the analog settings.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, SDA is released (sda_oe=0) and cal_start is 0. Register 0x01 holds 0x02, registers 0x06 to 0x08 hold 0x40, and every other writable register holds 0x00. Register 0x00 reads 0x10: identity value 1 in bits 7:4 and revision 0 in bits 3:0.
- R2: The target acknowledges an address byte only when its upper seven bits equal 1,0,0,0,1,addr_sel[1],addr_sel[0], sent MSB first. Bit 0 of the address byte is the direction: 1 means read. On a mismatch the target acknowledges nothing and changes no register until the next START.
- R3: Before a START has been seen, clock pulses and data on the bus cause no acknowledge and no register change.
- R4: In a write, the first byte after the address is the register pointer. Each later byte is stored at the pointer, and the pointer then advances by one. The target acknowledges the pointer byte and every data byte.
- R5: In a read, bytes are returned MSB first, starting at the pointer, and the pointer advances by one after each byte. The read goes on while the host acknowledges. After a host NACK, the target drives SDA no more until the next START.
- R6: A repeated START ends the current transfer and starts a new address phase, and the pointer keeps its value.
- R7: Writes to register 0x00, to the reserved registers 0x0D to 0x12 and to any pointer above 0x13 change nothing. The reserved and unimplemented registers read as 0x00.
- R8: Writing register 0x0C stores the whole byte, and its bit 0 drives cal_start. A cal_done pulse clears bit 0. A write that lands in the same cycle as the pulse takes priority.
- R9: The pointer wraps from 0xFF to 0x00.
- R10: A pulse on either line shorter than FILT clock cycles is ignored. It creates no START or STOP and does not change a sampled bit.
- R11: The target changes sda_oe only while SCL is low. The change comes at least FILT+HOLD clock cycles after the SCL falling edge, provided each SCL phase lasts longer than FILT+HOLD+3 cycles. With the 200 MHz default clock this covers 400 kHz buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| addr_sel | input | 2 | Pin-selected low address bits |
| cal_done | input | 1 | Calibration finished, clears the start command bit |
| sda_oe | output | 1 | 1 pulls SDA low |
| cal_start | output | 1 | Calibration start command (register 0x0C bit 0) |
| cfg_flat | output | 8*NREG | Register i on bits 8*i+7 down to 8*i |

## Verification
The bench goes after the following corner cases:
- **Pointer wrap.** A burst is written across the pointer wrap: 0xFF, then 0x00, then 0x01. A design that failed to wrap, or that let 0x00 be written, would leave a wrong byte in register 0x01 or corrupt the identity byte.
- **Address mismatch.** The bench sends a foreign address and then a full write. A target that acknowledged it or stored the data would show up through the ACK bits and the register bus.
- **Read termination.** After a NACK that ends a read, the bench keeps clocking. A target that kept driving SDA would pull the line low.
- **Glitch rejection.** A glitch is placed inside the high phase of a data bit. A missing filter would turn it into a false STOP or a zero bit.
- **Drive timing.** Every change of sda_oe is timed against SCL. Logic that drove on the edge itself, or while SCL was high, is reported.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int          NREG    = 20,
  parameter int          FILT    = 12,
  parameter int          HOLD    = 4,
  parameter logic [4:0]  PREFIX  = 5'b10001,
  parameter logic [3:0]  ID_VAL  = 4'h1,
  parameter logic [3:0]  REV_VAL = 4'h0,
  parameter logic [7:0]  RSV_LO  = 8'h0D,
  parameter logic [7:0]  RSV_HI  = 8'h12,
  parameter int          CAL_REG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        addr_sel,
  input  logic              cal_done,
  output logic              sda_oe,
  output logic              cal_start,
  output logic [8*NREG-1:0] cfg_flat
);
  localparam int         IW   = $clog2(NREG);
  localparam int         FW   = $clog2(FILT + 1);
  localparam int         HW   = $clog2(HOLD + 1);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  typedef enum logic [3:0] {
    IDLE = 4'd0, ADDR = 4'd1, AACK = 4'd2, PTR = 4'd3, PACK = 4'd4,
    WDATA = 4'd5, WACK = 4'd6, RDATA = 4'd7, RACK = 4'd8
  } st_t;

  function automatic logic [7:0] dflt(int i);
    if (i == 1) return 8'h02;
    if (i >= 6 && i <= 8) return 8'h40;
    return 8'h00;
  endfunction

  logic [1:0]    s1, s2, filt, fq;
  logic [FW-1:0] fcnt [2];
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, rsh, ptr, rd_byte;
  logic          rw, nack;
  logic [HW-1:0] hcnt;
  logic [7:0]    regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 2'b11;
      s2   <= 2'b11;
      filt <= 2'b11;
      fq   <= 2'b11;
      for (int g = 0; g < 2; g++) fcnt[g] <= '0;
    end else begin
      s1 <= {scl_in, sda_in};
      s2 <= s1;
      fq <= filt;
      for (int g = 0; g < 2; g++) begin
        if (s2[g] == filt[g]) fcnt[g] <= '0;
        else if (fcnt[g] == FW'(FILT - 1)) begin
          filt[g] <= s2[g];
          fcnt[g] <= '0;
        end else fcnt[g] <= fcnt[g] + 1'b1;
      end
    end
  end

  wire scl_rise = filt[1] & ~fq[1];
  wire scl_fall = ~filt[1] & fq[1];
  wire bus_start = filt[1] & fq[1] & fq[0] & ~filt[0];
  wire bus_stop  = filt[1] & fq[1] & ~fq[0] & filt[0];
  wire addr_hit  = sh[7:1] == {PREFIX, addr_sel};
  wire wr_ok     = (ptr != 8'h00) && (ptr <= LAST) && !(ptr >= RSV_LO && ptr <= RSV_HI);
  wire oe_next   = (st == AACK) || (st == PACK) || (st == WACK) || (st == RDATA && !rsh[7]);

  always_comb begin
    if (ptr == 8'h00)     rd_byte = {ID_VAL, REV_VAL};
    else if (ptr <= LAST) rd_byte = regs[ptr[IW-1:0]];
    else                  rd_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      sh     <= '0;
      rsh    <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      hcnt   <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else begin
      if (cal_done) regs[CAL_REG][0] <= 1'b0;
      if (bus_start) begin
        st  <= ADDR;
        cnt <= '0;
      end else if (bus_stop) begin
        st <= IDLE;
      end else if (scl_rise) begin
        case (st)
          ADDR, PTR, WDATA: begin
            sh  <= {sh[6:0], filt[0]};
            cnt <= cnt + 1'b1;
          end
          RDATA:   cnt  <= cnt + 1'b1;
          RACK:    nack <= filt[0];
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ADDR: if (cnt == 4'd8) begin
            cnt <= '0;
            rw  <= sh[0];
            st  <= addr_hit ? AACK : IDLE;
          end
          AACK: begin
            cnt <= '0;
            if (rw) begin
              rsh <= rd_byte;
              ptr <= ptr + 1'b1;
              st  <= RDATA;
            end else st <= PTR;
          end
          PTR: if (cnt == 4'd8) begin
            cnt <= '0;
            ptr <= sh;
            st  <= PACK;
          end
          PACK, WACK: st <= WDATA;
          WDATA: if (cnt == 4'd8) begin
            cnt <= '0;
            if (wr_ok) regs[ptr[IW-1:0]] <= sh;
            ptr <= ptr + 1'b1;
            st  <= WACK;
          end
          RDATA: begin
            if (cnt == 4'd8) begin
              cnt <= '0;
              st  <= RACK;
            end else rsh <= {rsh[6:0], 1'b0};
          end
          RACK: begin
            if (nack) st <= IDLE;
            else begin
              rsh <= rd_byte;
              ptr <= ptr + 1'b1;
              st  <= RDATA;
            end
          end
          default: ;
        endcase
      end
      if (scl_fall) hcnt <= HW'(HOLD);
      else if (hcnt != '0) begin
        hcnt <= hcnt - 1'b1;
        if (hcnt == HW'(1)) sda_oe <= oe_next;
      end
    end
  end

  assign cal_start = regs[CAL_REG][0];

  for (genvar i = 0; i < NREG; i++) begin : g_out
    if (i == 0) begin : g_id
      assign cfg_flat[7:0] = {ID_VAL, REV_VAL};
    end else begin : g_rw
      assign cfg_flat[8*i +: 8] = regs[i];
    end
  end
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       cal_start,
  input logic       cal_done,
  input logic [3:0] st_q
);
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);

  a_r8_cal_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_start) |-> $past(st_q) == 4'd5);

  a_r8_cal_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_start) |-> ($past(cal_done) || $past(st_q) == 4'd5));

  a_r3_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> st_q != 4'd0);

  a_r5_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 4'd0 && $past(st_q) == 4'd8) |-> !sda_oe);
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .cal_start(cal_start), .cal_done(cal_done), .st_q(st)
);

// File: tb/sim_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_cfg_i2c_target;
  localparam int NREG = 20;
  localparam int FILT = 12;
  localparam int HOLD = 4;
  localparam int Q    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic cal_done = 1'b0;
  logic glitch = 1'b0;
  logic sda_oe, cal_start;
  logic [8*NREG-1:0] cfg_flat;
  wire sda_line = host_sda & ~sda_oe;

  int tests = 0, fails = 0;
  int oe_cnt = 0, bad_timing = 0, since = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .cal_done(cal_done), .sda_oe(sda_oe),
    .cal_start(cal_start), .cfg_flat(cfg_flat)
  );

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    since <= scl ? 0 : since + 1;
    if (rst_n && sda_oe != prev_oe && (scl || since < FILT + HOLD)) bad_timing <= bad_timing + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] aw(input logic [1:0] sel, input logic rd);
    return {5'b10001, sel, rd};
  endfunction

  function automatic logic [7:0] reg_of(input int i);
    return cfg_flat[8*i +: 8];
  endfunction

  task automatic start_c();
    host_sda = 1'b0; wq(Q); scl = 1'b0;
  endtask

  task automatic rstart_c();
    wq(Q); host_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); host_sda = 1'b0; wq(Q); scl = 1'b0;
  endtask

  task automatic stop_c();
    wq(Q); host_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); host_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); host_sda = b[i]; wq(Q); scl = 1'b1;
      if (glitch && b[i]) begin
        wq(Q/2); host_sda = 1'b0; wq(4); host_sda = 1'b1; wq(2*Q - Q/2 - 4);
      end else wq(2*Q);
      scl = 1'b0;
    end
    wq(Q); host_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(2*Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0;
    end
    wq(Q); host_sda = ~give_ack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0;
    wq(Q); host_sda = 1'b1;
  endtask

  task automatic write1(input logic [7:0] p, input logic [7:0] d, input string tag);
    logic a0, a1, a2;
    start_c(); send_byte(aw(addr_sel, 1'b0), a0); send_byte(p, a1); send_byte(d, a2); stop_c();
    chk({tag, " write acks"}, {29'd0, a0, a1, a2}, 32'd7);
  endtask

  task automatic read1(input logic [7:0] p, output logic [7:0] v);
    logic a0, a1, a2;
    start_c(); send_byte(aw(addr_sel, 1'b0), a0); send_byte(p, a1);
    rstart_c(); send_byte(aw(addr_sel, 1'b1), a2); recv_byte(1'b0, v); stop_c();
  endtask

  localparam logic [23:0] VEC [8] = '{
    {8'h02, 8'hA5, 8'hA5},
    {8'h00, 8'h77, 8'h10},
    {8'h0D, 8'h33, 8'h00},
    {8'h12, 8'hFF, 8'h00},
    {8'h07, 8'h7F, 8'h7F},
    {8'h13, 8'h06, 8'h06},
    {8'h40, 8'h12, 8'h00},
    {8'h0C, 8'h06, 8'h06}
  };

  initial begin
    logic [7:0] v;
    logic a0, a1, a2, a3;
    int o0;
    wq(10); rst_n = 1'b1; wq(10);

    // R1 reset state on the register bus
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 cal_start", {31'd0, cal_start}, 32'd0);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h10 : (i == 1) ? 8'h02 : (i >= 6 && i <= 8) ? 8'h40 : 8'h00;
      chk($sformatf("R1 reg%0d", i), {24'd0, reg_of(i)}, {24'd0, e});
    end

    // R3 clocking without START
    o0 = oe_cnt;
    scl = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); host_sda = aw(2'b00, 1'b0)
        [i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0;
    end
    wq(Q); host_sda = 1'b1; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    chk("R3 no drive before START", oe_cnt - o0, 0);
    scl = 1'b1; wq(2*Q);

    // R1/R5/R6 burst read of defaults
    start_c(); send_byte(aw(addr_sel, 1'b0), a0); send_byte(8'h00, a1);
    rstart_c(); send_byte(aw(addr_sel, 1'b1), a2);
    chk("R6 acks around repeated START", {29'd0, a0, a1, a2}, 32'd7);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h10 : (i == 1) ? 8'h02 : (i >= 6) ? 8'h40 : 8'h00;
      recv_byte(i != 8, v);
      chk($sformatf("R5 burst byte %0d", i), {24'd0, v}, {24'd0, e});
    end
    o0 = oe_cnt;
    for (int i = 0; i < 9; i++) begin
      wq(2*Q); scl = 1'b1; wq(2*Q); scl = 1'b0;
    end
    chk("R5 released after NACK", oe_cnt - o0, 0);
    stop_c();

    // R4/R7/R8 vector table: write then read back
    for (int k = 0; k < 8; k++) begin
      write1(VEC[k][23:16], VEC[k][15:8], "R4");
      read1(VEC[k][23:16], v);
      chk($sformatf("R7 readback ptr %0h", VEC[k][23:16]), {24'd0, v}, {24'd0, VEC[k][7:0]});
    end
    chk("R8 bit0 clear write keeps cal_start low", {31'd0, cal_start}, 32'd0);

    // R4 burst write with auto-increment
    start_c(); send_byte(aw(addr_sel, 1'b0), a0); send_byte(8'h03, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3); send_byte(8'h33, a0); stop_c();
    chk("R4 burst acks", {30'd0, a2, a3}, 32'd3);
    chk("R4 burst regs", {8'd0, reg_of(3), reg_of(4), reg_of(5)}, 32'h00112233);

    // R9 pointer wrap: 0xFF -> 0x00 (ignored) -> 0x01
    start_c(); send_byte(aw(addr_sel, 1'b0), a0); send_byte(8'hFF, a1);
    send_byte(8'h55, a2); send_byte(8'hAB, a3); send_byte(8'h99, a0); stop_c();
    chk("R9 wrap lands on reg1", {24'd0, reg_of(1)}, 32'h99);
    chk("R7 reg0 unchanged after wrap", {24'd0, reg_of(0)}, 32'h10);

    // R2 address mismatch, then new pin address
    start_c(); send_byte(aw(2'b01, 1'b0), a0); send_byte(8'h02, a1); send_byte(8'h00, a2); stop_c();
    chk("R2 mismatch no acks", {29'd0, a0, a1, a2}, 32'd0);
    chk("R2 mismatch no write", {24'd0, reg_of(2)}, 32'hA5);
    addr_sel = 2'b11;
    write1(8'h09, 8'h3C, "R2");
    chk("R2 pin address write", {24'd0, reg_of(9)}, 32'h3C);

    // R8 calibration command bit
    write1(8'h0C, 8'h05, "R8");
    chk("R8 cal_start set", {31'd0, cal_start}, 32'd1);
    chk("R8 reg 0x0C byte", {24'd0, reg_of(12)}, 32'h05);
    cal_done = 1'b1; wq(1); cal_done = 1'b0; wq(2);
    chk("R8 cal_start cleared", {31'd0, cal_start}, 32'd0);
    chk("R8 other bits kept", {24'd0, reg_of(12)}, 32'h04);

    // R10 glitches inside high phases of data bits
    glitch = 1'b1;
    write1(8'h0A, 8'hF7, "R10");
    glitch = 1'b0;
    chk("R10 glitched byte intact", {24'd0, reg_of(10)}, 32'hF7);

    // R11 drive timing seen over the whole run
    chk("R11 sda_oe timing", bad_timing, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule